// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps the contents of a dynamic memory alive by visiting every row within the retention window. An interval timer, stepped by an external tick, splits the retention period evenly across all rows. At the end of each slice one more refresh becomes owed. While any refresh is owed, the scheduler asks the main memory controller for the strobes. Once granted, it runs one row-strobe-only cycle for the current row and then advances the row counter.

Two cycle flavours are offered. In the normal flavour the column strobe stays inactive, which keeps the data output in high impedance and saves power. In the hidden flavour the controller has the column strobe held low from a read that just finished. The scheduler keeps the column strobe low for the whole cycle and pulses only the row strobe, so the read data on the output stays valid. Refreshes that the controller keeps waiting are counted. A sticky flag reports that a slice expired while the count was already at its ceiling, meaning a refresh has been lost.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and straight after reset: req_o=0, ras_n_o=1, cas_n_o=1, addr_o=0, done_o=0, owed_o=0, overdue_o=0.
- R2: One refresh is added to the owed count each time INTERVAL tick pulses have been counted. INTERVAL = floor(TICK_KHZ*RETENTION_US/1000 / 2^ROW_W), which is 15 for the defaults. A slice ends in the clock cycle of its INTERVAL-th tick, and the count shows it on the next cycle.
- R3: addr_o[ROW_W-1:0] carries the current row and every bit above it is 0. The row starts at 0 and advances by one, modulo 2^ROW_W, on the clock edge that ends the cycle in which done_o is high. It does not change at any other time.
- R4: When the scheduler is idle and sees an owed count above zero, req_o rises on the next cycle and stays high until a cycle in which gnt_i is high.
- R5: The grant edge starts the strobe cycle. ras_n_o is then low for exactly RAS_LOW_CYC cycles and high for RAS_PRE_CYC precharge cycles. done_o is high in the last precharge cycle only, and the scheduler returns to idle on the next cycle.
- R6: If hidden_i is low in the grant cycle, cas_n_o stays 1 for the whole strobe cycle.
- R7: If hidden_i is high in the grant cycle, cas_n_o is 0 from the first row-strobe cycle through the last precharge cycle.
- R8: owed_o saturates at MAX_OWED. When a slice ends in the same cycle as done_o, owed_o is unchanged.
- R9: overdue_o becomes 1 when a slice ends while owed_o equals MAX_OWED and done_o is low. It stays 1 until reset.
- R10: Outside a strobe cycle, ras_n_o and cas_n_o are 1. While req_o is low, gnt_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Time-base tick at TICK_KHZ |
| gnt_i | input | 1 | Controller grants the strobes |
| hidden_i | input | 1 | Controller holds the column strobe low from a read |
| req_o | output | 1 | Refresh request |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ADDR_W | Refresh row address, upper bit(s) zero |
| done_o | output | 1 | Last precharge cycle of a refresh |
| owed_o | output | OWED_W | Refreshes owed |
| overdue_o | output | 1 | Sticky lost-refresh flag |

## Verification
The hardest state to reach from the ports is the lost refresh. It needs MAX_OWED+1 slices to end with no grant in between, and then the owed count must drain again. The stimulus withholds gnt_i for well over that many slices while ticking every cycle. It then grants continuously and sweeps the row counter past its wrap point. The hidden flavour is mixed in by toggling hidden_i so that grants land on both of its values.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_RAS_LOW = 2'd2,
    ST_PRECH   = 2'd3
  } rfsh_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int INTERVAL = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic expire_o
);
  localparam int TMR_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (tick_i) begin
      if (cnt_q == TMR_W'(INTERVAL - 1)) begin
        cnt_d    = '0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rfsh_debt_ledger.sv
module rfsh_debt_ledger #(
  parameter int MAX_OWED = 4,
  parameter int OWED_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire_i,
  input  logic              done_i,
  output logic [OWED_W-1:0] owed_o,
  output logic              overdue_o,
  output logic              pending_o
);
  logic [OWED_W-1:0] owed_q, owed_d;
  logic              over_q, over_d;
  logic              at_cap;

  assign at_cap = (owed_q == OWED_W'(MAX_OWED));

  always_comb begin
    owed_d = owed_q;
    over_d = over_q;
    if (expire_i && !done_i) begin
      if (at_cap) over_d = 1'b1;
      else        owed_d = owed_q + 1'b1;
    end else if (done_i && !expire_i) begin
      owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      over_q <= 1'b0;
    end else begin
      owed_q <= owed_d;
      over_q <= over_d;
    end
  end

  assign owed_o    = owed_q;
  assign overdue_o = over_q;
  assign pending_o = (owed_q != '0);
endmodule

// File: rtl/rfsh_cycle_seq.sv
module rfsh_cycle_seq
  import dram_refresh_pkg::*;
#(
  parameter int ROW_W       = 8,
  parameter int RAS_LOW_CYC = 4,
  parameter int RAS_PRE_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending_i,
  input  logic             gnt_i,
  input  logic             hidden_i,
  output logic             req_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] row_o,
  output logic             done_o
);
  localparam int LONGEST = (RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC;
  localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  rfsh_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hid_q, hid_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             ras_n_q, ras_n_d, cas_n_q, cas_n_d;
  logic             last_cnt;

  assign last_cnt = (cnt_q == '0);
  assign done_o   = (st_q == ST_PRECH) && last_cnt;
  assign req_o    = (st_q == ST_REQ);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    hid_d = hid_q;
    row_d = row_q;
    unique case (st_q)
      ST_IDLE: if (pending_i) st_d = ST_REQ;
      ST_REQ: if (gnt_i) begin
        st_d  = ST_RAS_LOW;
        cnt_d = CNT_W'(RAS_LOW_CYC - 1);
        hid_d = hidden_i;
      end
      ST_RAS_LOW: begin
        if (last_cnt) begin
          st_d  = ST_PRECH;
          cnt_d = CNT_W'(RAS_PRE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_PRECH: begin
        if (last_cnt) begin
          st_d  = ST_IDLE;
          row_d = row_q + 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    ras_n_d = (st_d != ST_RAS_LOW);
    cas_n_d = !(((st_d == ST_RAS_LOW) || (st_d == ST_PRECH)) && hid_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      hid_q   <= 1'b0;
      row_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      hid_q   <= hid_d;
      row_q   <= row_d;
      ras_n_q <= ras_n_d;
      cas_n_q <= cas_n_d;
    end
  end

  assign ras_n_o = ras_n_q;
  assign cas_n_o = cas_n_q;
  assign row_o   = row_q;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int TICK_KHZ     = 1000,
  parameter int RETENTION_US = 4000,
  parameter int ROW_W        = 8,
  parameter int ADDR_W       = 9,
  parameter int RAS_LOW_CYC  = 4,
  parameter int RAS_PRE_CYC  = 3,
  parameter int MAX_OWED     = 4,
  parameter int OWED_W       = $clog2(MAX_OWED + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              gnt_i,
  input  logic              hidden_i,
  output logic              req_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic [OWED_W-1:0] owed_o,
  output logic              overdue_o
);
  localparam int NUM_ROWS    = 1 << ROW_W;
  localparam int WINDOW_TICK = (TICK_KHZ * RETENTION_US) / 1000;
  localparam int INTERVAL    = WINDOW_TICK / NUM_ROWS;

  logic             expire;
  logic             pending;
  logic [ROW_W-1:0] row;

  rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .expire_o(expire)
  );

  rfsh_debt_ledger #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_ledger (
    .clk(clk), .rst_n(rst_n), .expire_i(expire), .done_i(done_o),
    .owed_o(owed_o), .overdue_o(overdue_o), .pending_o(pending)
  );

  rfsh_cycle_seq #(
    .ROW_W(ROW_W), .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pending_i(pending), .gnt_i(gnt_i),
    .hidden_i(hidden_i), .req_o(req_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .row_o(row), .done_o(done_o)
  );

  assign addr_o = {{(ADDR_W - ROW_W){1'b0}}, row};
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROW_W    = 8,
  parameter int ADDR_W   = 9,
  parameter int MAX_OWED = 4,
  parameter int OWED_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gnt_i,
  input logic              req_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic [OWED_W-1:0] owed_o,
  input logic              overdue_o
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> req_o); // R4
  AST_GRANT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> !ras_n_o); // R5
  AST_DONE_IN_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ras_n_o); // R5
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> addr_o[ROW_W-1:0] == ROW_W'($past(addr_o[ROW_W-1:0]) + 1'b1)); // R3
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(addr_o)); // R3
  AST_CAS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(cas_n_o)); // R7
  AST_OWED_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    owed_o <= OWED_W'(MAX_OWED)); // R8
  AST_OVERDUE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overdue_o |=> overdue_o); // R9
  AST_NO_REQ_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |-> !req_o); // R10
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .ROW_W(ROW_W), .ADDR_W(ADDR_W), .MAX_OWED(MAX_OWED), .OWED_W(OWED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gnt_i(gnt_i), .req_o(req_o),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .addr_o(addr_o), .done_o(done_o),
  .owed_o(owed_o), .overdue_o(overdue_o)
);

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 8, ADDR_W = 9, LOW = 4, PRE = 3, MAXO = 4, OWED_W = 3;
  localparam int INTERVAL = 15; // 1000 kHz * 4000 us / 1000 / 256

  logic clk, rst_n, tick_i, gnt_i, hidden_i;
  logic req_o, ras_n_o, cas_n_o, done_o, overdue_o;
  logic [ADDR_W-1:0] addr_o;
  logic [OWED_W-1:0] owed_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  dram_refresh_sched #(
    .TICK_KHZ(1000), .RETENTION_US(4000), .ROW_W(ROW_W), .ADDR_W(ADDR_W),
    .RAS_LOW_CYC(LOW), .RAS_PRE_CYC(PRE), .MAX_OWED(MAXO), .OWED_W(OWED_W)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gnt_i(gnt_i),
    .hidden_i(hidden_i), .req_o(req_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .addr_o(addr_o), .done_o(done_o),
    .owed_o(owed_o), .overdue_o(overdue_o)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: phase 0 idle, 1 asking, 2 row strobe low, 3 precharge
  int m_phase, m_left, m_row, m_tcnt, m_cycle;
  bit m_hid, m_over;
  int m_debt[$];

  function automatic bit m_done();
    return (m_phase == 3) && (m_left == 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_row = 0; m_tcnt = 0; m_hid = 0; m_over = 0;
      m_cycle = 0; m_debt.delete();
    end else begin
      bit fire, fin;
      int debt_before;
      m_cycle++;
      fin = m_done();
      debt_before = m_debt.size();
      fire = 0;
      if (tick_i) begin
        if (m_tcnt == INTERVAL - 1) begin m_tcnt = 0; fire = 1; end
        else m_tcnt++;
      end
      if (fin) void'(m_debt.pop_front());
      if (fire) begin
        if (m_debt.size() < MAXO) m_debt.push_back(m_cycle);
        else m_over = 1;
      end
      case (m_phase)
        0: if (debt_before > 0) m_phase = 1;
        1: if (gnt_i) begin m_phase = 2; m_left = LOW; m_hid = hidden_i; end
        2: if (m_left == 1) begin m_phase = 3; m_left = PRE; end else m_left--;
        default: if (m_left == 1) begin m_phase = 0; m_row = (m_row + 1) % 256; end
                 else m_left--;
      endcase
    end
  end

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  int prev_addr = 0;
  bit wrap_seen = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_eq("R4 req_o", req_o, m_phase == 1);
      check_eq("R5 ras_n_o", ras_n_o, m_phase != 2);
      check_eq("R6/R7 cas_n_o", cas_n_o, ((m_phase == 2 || m_phase == 3) && m_hid) ? 0 : 1);
      check_eq("R3 addr_o", addr_o, m_row);
      check_eq("R5 done_o", done_o, m_done());
      check_eq("R2/R8 owed_o", owed_o, m_debt.size());
      check_eq("R9 overdue_o", overdue_o, m_over);
      if (prev_addr == 255 && addr_o == 0) wrap_seen = 1;
      prev_addr = addr_o;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; tick_i = 0; gnt_i = 0; hidden_i = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check_eq("R1 req_o", req_o, 0);
    check_eq("R1 ras_n_o", ras_n_o, 1);
    check_eq("R1 cas_n_o", cas_n_o, 1);
    check_eq("R1 addr_o", addr_o, 0);
    check_eq("R1 owed_o", owed_o, 0);
    check_eq("R1 overdue_o", overdue_o, 0);
    check_eq("R1 done_o", done_o, 0);
    rst_n = 1;
    // R10: grant held while nothing is owed must be ignored; normal cycles (R6)
    gnt_i = 1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); tick_i = 1;
    end
    // R7: hidden and normal cycles mixed, irregular ticks and grants
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      tick_i = (i % 3) != 1;
      hidden_i = i[3];
      gnt_i = (i % 5) != 0;
    end
    // R8/R9: withhold grants until the debt saturates and a slice is lost
    for (int i = 0; i < 120; i++) begin
      @(negedge clk); tick_i = 1; gnt_i = 0; hidden_i = 0;
    end
    @(negedge clk);
    check_eq("R9 overdue after backlog", overdue_o, 1);
    check_eq("R8 owed at ceiling", owed_o, MAXO);
    // drain and sweep past the row wrap (R3)
    for (int i = 0; i < 4200; i++) begin
      @(negedge clk); tick_i = 1; gnt_i = 1; hidden_i = i[2];
    end
    @(negedge clk);
    check_eq("R3 row wrap observed", wrap_seen, 1);
    check_eq("R9 overdue still set", overdue_o, 1);
    finish_run();
  end
endmodule